// File: doc/BRIEF.md
# Programmable-Matrix CRC Checker

This block checks a framed stream of 32-bit words on the receive side of a serial link. A frame starts with a word flagged as start-of-packet and ends its payload with a word flagged as end-of-packet. The next valid word after that carries the transmitter's 16-bit CRC in its low half. The checker recomputes the CRC over the payload, one whole word per clock. It then XORs the recomputed value with the received one. Any set bit in that difference produces a one-cycle error flag, which comes out together with a one-cycle done flag.

The CRC update is not wired for one polynomial. Each of the 16 next-state bits is the parity of a 48-bit row of a writable matrix ANDed with the concatenation of the current CRC and the data word. Loading a new matrix through the row write port therefore changes the polynomial with no change to the logic. At reset the matrix holds the rows for the polynomial 0x1021, and the running CRC is seeded with 0xFFFF. Two test controls are provided. A bypass input suppresses the result of a check, and an inject input forces a detected error so that the downstream error path can be exercised.

Top module: `crcchk_top`

## Requirements
- R1: After reset `chkDone` and `chkErr` are low, the running CRC seed is 0xFFFF and the matrix implements polynomial 0x1021.
- R2: The CRC is computed over the payload as a non-reflected serial CRC, bit 31 of each word first: for each bit b, fb = crc[15]^b and crc = (crc<<1) ^ (fb ? poly : 0). The computation starts from 0xFFFF at the start-of-packet word.
- R3: The received CRC is bits [15:0] of the first valid word after the end-of-packet word, and bits [31:16] of that word have no effect on the result.
- R4: `chkDone` pulses high for exactly one cycle, in the cycle after the clock edge that accepts the CRC word. `chkErr` is high only together with `chkDone`.
- R5: `chkErr` pulses whenever the XOR of the received and recomputed CRCs is nonzero, including a single flipped bit at either end of the field.
- R6: Writing `mtxData` with `mtxWe` high loads matrix row `mtxRow` (next-state bit index 0..15). Bits [47:32] of a row weight CRC bits [15:0] and bits [31:0] weight data bits [31:0]. Loading the rows of another polynomial makes the check follow that polynomial.
- R7: A CRC word accepted while `bypass` is high produces neither a `chkDone` nor a `chkErr` pulse, whether or not the CRCs match.
- R8: A CRC word accepted while `errInject` is high produces a `chkErr` pulse even when the CRCs match.
- R9: A start-of-packet word always reloads the seed, even if the previous packet is unfinished or its CRC word never arrived. An abandoned packet produces no pulse.
- R10: Cycles with `inValid` low leave the computation unchanged, so gaps inside a packet do not alter the result. Valid words outside a packet that do not carry start-of-packet are ignored.
- R11: A packet whose single payload word carries both start-of-packet and end-of-packet is checked correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Word on `inData` is valid this cycle |
| inSop | input | 1 | Valid word is the first payload word |
| inEop | input | 1 | Valid word is the last payload word |
| inData | input | 32 | Payload word or CRC word |
| mtxWe | input | 1 | Matrix row write enable |
| mtxRow | input | 4 | Matrix row to write |
| mtxData | input | 48 | Row contents: [47:32] CRC weights, [31:0] data weights |
| bypass | input | 1 | Suppress the result of the check |
| errInject | input | 1 | Force an error on the check |
| chkDone | output | 1 | One-cycle pulse: a CRC word was checked |
| chkErr | output | 1 | One-cycle pulse: the check failed |

## Verification
The hardest state to reach from the ports is a packet cut short. Two cases matter: a start-of-packet arriving mid-payload, and one arriving in the slot where the CRC word was due. In both, the seed must reload with no stray pulse. The bench reaches both by sending partial and payload-only frames directly followed by complete frames whose CRC is predicted from a fresh seed. It also reprograms the whole matrix for a second polynomial through the row port, checks a frame against each polynomial, and then resets to confirm the default rows return.

// File: rtl/crcchk_pkg.sv
package crcchk_pkg;

  parameter int unsigned CHK_DATA_W = 32;
  parameter int unsigned CHK_CRC_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_TAIL = 2'd2
  } chkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadSeed;
    logic advance;
    logic check;
    logic suppress;
    logic inject;
  } chkStrobe_t;

endpackage

// File: rtl/crcchk_matrix.sv
module crcchk_matrix #(
  parameter int unsigned DATA_W = crcchk_pkg::CHK_DATA_W,
  parameter int unsigned CRC_W  = crcchk_pkg::CHK_CRC_W,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  localparam int unsigned IN_W   = DATA_W + CRC_W,
  localparam int unsigned ROW_AW = $clog2(CRC_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mtxWe,
  input  logic [ROW_AW-1:0] mtxRow,
  input  logic [IN_W-1:0]   mtxData,
  input  logic [CRC_W-1:0]  crcIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [CRC_W-1:0]  crcNext
);

  // Derive the reset rows by running a unit vector through the serial update
  function automatic logic [CRC_W-1:0][IN_W-1:0] buildRows(logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0][IN_W-1:0] m;
    logic [IN_W-1:0]   vec;
    logic [CRC_W-1:0]  c;
    logic [DATA_W-1:0] d;
    logic              fb;
    m = '0;
    for (int col = 0; col < int'(IN_W); col++) begin
      vec = '0;
      vec[col] = 1'b1;
      c = vec[IN_W-1:DATA_W];
      d = vec[DATA_W-1:0];
      for (int b = int'(DATA_W) - 1; b >= 0; b--) begin
        fb = c[CRC_W-1] ^ d[b];
        c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      for (int i = 0; i < int'(CRC_W); i++) m[i][col] = c[i];
    end
    return m;
  endfunction

  localparam logic [CRC_W-1:0][IN_W-1:0] RESET_ROWS = buildRows(POLY);

  logic [CRC_W-1:0][IN_W-1:0] rows;
  logic [IN_W-1:0] operand;

  assign operand = {crcIn, dataIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rows <= RESET_ROWS;
    end else if (mtxWe) begin
      rows[mtxRow] <= mtxData;
    end
  end

  // one parity tree per next-state bit
  for (genvar i = 0; i < int'(CRC_W); i++) begin : g_row
    assign crcNext[i] = ^(rows[i] & operand);
  end

  a_r6_row_write: assert property (@(posedge clk) disable iff (!rstN)
    mtxWe |=> rows[$past(mtxRow)] == $past(mtxData))
    else $error("R6: matrix row not loaded");

endmodule

// File: rtl/crcchk_ctrl.sv
module crcchk_ctrl
  import crcchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSop,
  input  logic       inEop,
  input  logic       bypass,
  input  logic       errInject,
  output chkStrobe_t stb
);

  chkState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    stb          = '0;
    stb.suppress = bypass;
    stb.inject   = errInject;
    if (inValid) begin
      if (inSop) begin
        // a start always restarts, whatever was pending
        stb.loadSeed = 1'b1;
        stb.advance  = 1'b1;
        stateNext    = inEop ? ST_TAIL : ST_BODY;
      end else begin
        unique case (state)
          ST_BODY: begin
            stb.advance = 1'b1;
            if (inEop) stateNext = ST_TAIL;
          end
          ST_TAIL: begin
            stb.check = 1'b1;
            stateNext = ST_IDLE;
          end
          default: stateNext = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  a_r3_check_in_tail: assert property (@(posedge clk) disable iff (!rstN)
    stb.check |-> (state == ST_TAIL && inValid && !inSop))
    else $error("R3: check outside CRC slot");

  a_r9_sop_starts: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSop && !inEop) |=> state == ST_BODY)
    else $error("R9: start-of-packet did not restart");

  a_r11_single_word: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSop && inEop) |=> state == ST_TAIL)
    else $error("R11: single-word packet not awaiting CRC");

  a_r10_gap_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(state))
    else $error("R10: state moved on idle cycle");

endmodule

// File: rtl/crcchk_dpath.sv
module crcchk_dpath
  import crcchk_pkg::*;
#(
  parameter int unsigned CRC_W = CHK_CRC_W,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  chkStrobe_t       stb,
  input  logic [CRC_W-1:0] rxCrc,
  input  logic [CRC_W-1:0] crcNext,
  output logic [CRC_W-1:0] crcIn,
  output logic             chkDone,
  output logic             chkErr
);

  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] diff;
  logic             report;

  assign crcIn  = stb.loadSeed ? SEED : crcReg;
  assign diff   = crcReg ^ rxCrc;
  assign report = stb.check & ~stb.suppress;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg  <= SEED;
      chkDone <= 1'b0;
      chkErr  <= 1'b0;
    end else begin
      if (stb.advance) crcReg <= crcNext;
      chkDone <= report;
      chkErr  <= report & ((|diff) | stb.inject);
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    chkDone |=> !chkDone)
    else $error("R4: done longer than one cycle");

  a_r4_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    chkErr |-> chkDone)
    else $error("R4: error without done");

  a_r5_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    (stb.check && !stb.suppress && (crcReg != rxCrc)) |=> chkErr)
    else $error("R5: mismatch not flagged");

  a_r7_bypass_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (stb.check && stb.suppress) |=> (!chkDone && !chkErr))
    else $error("R7: pulse under bypass");

  a_r8_inject: assert property (@(posedge clk) disable iff (!rstN)
    (stb.check && !stb.suppress && stb.inject) |=> chkErr)
    else $error("R8: injected error missing");

  a_r10_crc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(crcReg))
    else $error("R10: CRC changed without a payload word");

endmodule

// File: rtl/crcchk_top.sv
module crcchk_top
  import crcchk_pkg::*;
#(
  parameter int unsigned DATA_W = CHK_DATA_W,
  parameter int unsigned CRC_W  = CHK_CRC_W,
  parameter logic [CRC_W-1:0] POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF,
  localparam int unsigned IN_W   = DATA_W + CRC_W,
  localparam int unsigned ROW_AW = $clog2(CRC_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [DATA_W-1:0] inData,
  input  logic              mtxWe,
  input  logic [ROW_AW-1:0] mtxRow,
  input  logic [IN_W-1:0]   mtxData,
  input  logic              bypass,
  input  logic              errInject,
  output logic              chkDone,
  output logic              chkErr
);

  chkStrobe_t       stb;
  logic [CRC_W-1:0] crcIn;
  logic [CRC_W-1:0] crcNext;

  crcchk_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSop     (inSop),
    .inEop     (inEop),
    .bypass    (bypass),
    .errInject (errInject),
    .stb       (stb)
  );

  crcchk_matrix #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) matrix_i (
    .clk     (clk),
    .rstN    (rstN),
    .mtxWe   (mtxWe),
    .mtxRow  (mtxRow),
    .mtxData (mtxData),
    .crcIn   (crcIn),
    .dataIn  (inData),
    .crcNext (crcNext)
  );

  // only the low half of the trailing word is the received CRC
  crcchk_dpath #(.CRC_W(CRC_W), .SEED(SEED)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .rxCrc   (inData[CRC_W-1:0]),
    .crcNext (crcNext),
    .crcIn   (crcIn),
    .chkDone (chkDone),
    .chkErr  (chkErr)
  );

endmodule

// File: tb/crcchk_tb_top.sv
`timescale 1ns/1ps
module crcchk_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [31:0] inData = '0;
  logic        mtxWe = 1'b0;
  logic [3:0]  mtxRow = '0;
  logic [47:0] mtxData = '0;
  logic        bypass = 1'b0, errInject = 1'b0;
  logic        chkDone, chkErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  crcchk_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inData(inData), .mtxWe(mtxWe), .mtxRow(mtxRow), .mtxData(mtxData),
    .bypass(bypass), .errInject(errInject), .chkDone(chkDone), .chkErr(chkErr)
  );

  typedef struct packed {
    logic [4:0]  n;
    logic [31:0] base;
    logic [15:0] flip;
    logic [15:0] upper;
    logic        inj;
    logic        byp;
    logic        gap;
    logic        expDone;
    logic        expErr;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t TABLE [NVEC] = '{
    '{5'd4, 32'h12345678, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R2 R4
    '{5'd1, 32'hDEADBEEF, 16'h0000, 16'hA5A5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R11 R3
    '{5'd6, 32'h00000000, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
    '{5'd3, 32'hFFFFFFFF, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5
    '{5'd5, 32'h0F0F0F0F, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}, // R8
    '{5'd4, 32'h13572468, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7
    '{5'd4, 32'h13572468, 16'h00F0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R7
    '{5'd7, 32'h89ABCDEF, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R10
    '{5'd2, 32'h00000000, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}  // R3
  };

  function automatic logic [31:0] genWord(logic [31:0] base, int k);
    return base ^ (32'(k) * 32'h9E3779B9);
  endfunction

  // serial CRC step over one 32-bit word, bit 31 first
  function automatic logic [15:0] stepWord(logic [15:0] c, logic [31:0] w, logic [15:0] poly);
    logic fb;
    for (int b = 31; b >= 0; b--) begin
      fb = c[15] ^ w[b];
      c  = {c[14:0], 1'b0} ^ (fb ? poly : 16'h0);
    end
    return c;
  endfunction

  function automatic logic [15:0] modelCrc(int n, logic [31:0] base, logic [15:0] poly);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++) c = stepWord(c, genWord(base, k), poly);
    return c;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic beat(logic v, logic s, logic e, logic [31:0] d);
    @(negedge clk);
    inValid = v; inSop = s; inEop = e; inData = d;
  endtask

  task automatic runPacket(string req, int n, logic [31:0] base, logic [15:0] flip,
                           logic [15:0] upper, logic inj, logic byp, logic gap,
                           logic [15:0] poly, logic expDone, logic expErr);
    logic [15:0] c;
    c = modelCrc(n, base, poly);
    for (int k = 0; k < n; k++) begin
      beat(1'b1, k == 0, k == n - 1, genWord(base, k));
      if (gap) beat(1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF);
    end
    beat(1'b1, 1'b0, 1'b0, {upper, c ^ flip});
    errInject = inj; bypass = byp;
    beat(1'b0, 1'b0, 1'b0, '0);
    errInject = 1'b0; bypass = 1'b0;
    chk({req, " done"}, 32'(chkDone), 32'(expDone));
    chk({req, " err"}, 32'(chkErr), 32'(expErr));
    beat(1'b0, 1'b0, 1'b0, '0);
    chk({req, " done one cycle (R4)"}, 32'(chkDone), 32'd0);
    chk({req, " err one cycle (R4)"}, 32'(chkErr), 32'd0);
  endtask

  task automatic loadPoly(logic [15:0] poly);
    logic [15:0][47:0] rows;
    logic [47:0] vec;
    logic [15:0] c;
    rows = '0;
    for (int col = 0; col < 48; col++) begin
      vec = 48'd1 << col;
      c = stepWord(vec[47:32], vec[31:0], poly);
      for (int i = 0; i < 16; i++) rows[i][col] = c[i];
    end
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      mtxWe = 1'b1; mtxRow = 4'(r); mtxData = rows[r];
    end
    @(negedge clk);
    mtxWe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", 32'(chkDone), 32'd0);
    chk("R1 reset err", 32'(chkErr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      runPacket($sformatf("table[%0d]", i), int'(TABLE[i].n), TABLE[i].base,
                TABLE[i].flip, TABLE[i].upper, TABLE[i].inj, TABLE[i].byp,
                TABLE[i].gap, 16'h1021, TABLE[i].expDone, TABLE[i].expErr);
    end

    // R10: stray words outside a packet are ignored
    beat(1'b1, 1'b0, 1'b0, 32'h0000_1234);
    beat(1'b1, 1'b0, 1'b1, 32'h0000_5678);
    beat(1'b0, 1'b0, 1'b0, '0);
    chk("R10 stray words no done", 32'(chkDone), 32'd0);
    runPacket("R10 after stray", 3, 32'hCAFE0001, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0,
              16'h1021, 1'b1, 1'b0);

    // R9: packet cut off mid-payload, then a full one
    beat(1'b1, 1'b1, 1'b0, 32'h1111_1111);
    beat(1'b1, 1'b0, 1'b0, 32'h2222_2222);
    runPacket("R9 restart mid-payload", 4, 32'hA0A0A0A0, 16'h0, 16'h0, 1'b0, 1'b0,
              1'b0, 16'h1021, 1'b1, 1'b0);

    // R9: CRC slot taken by a new start-of-packet
    beat(1'b1, 1'b1, 1'b1, 32'h3333_3333);
    beat(1'b1, 1'b1, 1'b0, genWord(32'h55AA55AA, 0));
    chk("R9 abandoned packet no done", 32'(chkDone), 32'd0);
    beat(1'b1, 1'b0, 1'b1, genWord(32'h55AA55AA, 1));
    beat(1'b1, 1'b0, 1'b0, {16'h0, modelCrc(2, 32'h55AA55AA, 16'h1021)});
    beat(1'b0, 1'b0, 1'b0, '0);
    chk("R9 restart in CRC slot done", 32'(chkDone), 32'd1);
    chk("R9 restart in CRC slot err", 32'(chkErr), 32'd0);

    // R6: reprogram for polynomial 0x8005
    loadPoly(16'h8005);
    runPacket("R6 new polynomial match", 5, 32'h0BADF00D, 16'h0, 16'h0, 1'b0, 1'b0,
              1'b0, 16'h8005, 1'b1, 1'b0);
    runPacket("R6 old polynomial rejected", 5, 32'h0BADF00D, 16'h0, 16'h0, 1'b0,
              1'b0, 1'b0, 16'h1021, 1'b1,
              modelCrc(5, 32'h0BADF00D, 16'h1021) != modelCrc(5, 32'h0BADF00D, 16'h8005));

    // R1: reset restores default matrix
    doReset();
    chk("R1 after reset done", 32'(chkDone), 32'd0);
    runPacket("R1 default matrix restored", 4, 32'h0BADF00D, 16'h0, 16'h0, 1'b0,
              1'b0, 1'b0, 16'h1021, 1'b1, 1'b0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule